// File: doc/BRIEF.md
# SCSI DMA Channel Register File

This block is the control and status register set of one bus-master DMA channel inside a SCSI host adapter. Software reaches it through a simple register port: an index selects one of eight 32-bit slots, a write strobe loads the writable ones, and a combinational read path returns any slot. The slots hold a command word, the start values a transfer is programmed with (byte count, buffer address, descriptor-list address), the working copies of those values, and a status word.

A write to the command slot also issues an action chosen by its two low bits. The start action copies the three start values into their working slots, clears the stored status and asks the DMA engine to run. Idle asks it to stop, abort asks it to drop the current transfer, and burst-flush is accepted without effect. Each request reaches the engine as a one-cycle pulse. The engine reports error, abort and done events on set inputs. Software then clears those sticky status bits in one of two ways, chosen by a policy input: by writing ones to them, or by reading the status slot. The live interrupt line of the SCSI core is merged into every status read without being stored.

Top module: `dma_chan_regs`

## Requirements
- R1: Slots 0 (command), 1 (start count), 2 (start address) and 6 (start descriptor address) store all 32 written bits and return them on a read of the same index. Command bit 7 is the direction (1 = device to memory), bits 5 and 6 are the interrupt enables, bit 4 selects descriptor-list mode and bit 2 is diagnostic. All of them are stored without side effects.
- R2: Writes to slots 3 (working count), 4 (working address) and 7 (working descriptor address) are ignored, and the slots keep their values.
- R3: After reset, the command, the start slots and the working count read 0, the working address reads 0xFFFFFFFF, the working descriptor address reads 0xFFFFFFFD, and status reads 0 while the core interrupt is low.
- R4: A command write with bits [1:0] = 3 (start) copies slot 1 to slot 3, slot 2 to slot 4 and slot 6 to slot 7. It clears status bits 1 to 3 and raises `startPulse` in the cycle after the write.
- R5: A command write with bits [1:0] = 0 (idle) raises `stopPulse` and one with bits [1:0] = 2 (abort) raises `abortPulse`, each in the cycle after the write. Bits [1:0] = 1 (flush) raises no pulse and changes nothing except the stored command.
- R6: The three pulse outputs last one cycle per accepted command write, and at most one of them is high in any cycle.
- R7: An `evtSet` bit sets a sticky status bit: evtSet[0] sets bit 1 (error), evtSet[1] sets bit 2 (abort) and evtSet[2] sets bit 3 (done). A set in the same cycle as any clear wins.
- R8: With `clearOnRead` low, a write to slot 5 clears each of status bits 1, 2 and 3 that is written as 1 and leaves the others unchanged.
- R9: With `clearOnRead` high, writes to slot 5 are ignored, and a read of slot 5 returns the sticky bits and then clears bits 1 to 3.
- R10: Status bit 4 reads as the current level of `scsiIrq` and is never stored. Status bits 0, 5 and 31:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (drives the clear-on-read side effect) |
| addr | input | 3 | Register index |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| clearOnRead | input | 1 | Status clear policy: 0 write-one-to-clear, 1 clear-on-read |
| scsiIrq | input | 1 | Live SCSI core interrupt, merged into status bit 4 |
| evtSet | input | 3 | Engine events: [0] error, [1] abort, [2] done |
| startPulse | output | 1 | One-cycle request to run the DMA engine |
| stopPulse | output | 1 | One-cycle request to idle the DMA engine |
| abortPulse | output | 1 | One-cycle request to abort the current transfer |

## Verification
The checker tests every cycle that each pulse follows a matching command write and that no two pulses overlap. It also checks that status bit 4 follows the interrupt line whenever the status index is selected, and that a clear-on-read with no competing event leaves bits 1 to 3 zero. The snapshot contents after start, the reset values, the ignored writes to working slots and the write-one-to-clear masking involve stored register values. Only the bench's directed and random sequences, checked against a register model, can show these.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_CMD   = 3'd0,
    IDX_SCNT  = 3'd1,
    IDX_SADDR = 3'd2,
    IDX_WCNT  = 3'd3,
    IDX_WADDR = 3'd4,
    IDX_STAT  = 3'd5,
    IDX_SDESC = 3'd6,
    IDX_WDESC = 3'd7
  } regIdx_e;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_FLUSH = 2'd1,
    ACT_ABORT = 2'd2,
    ACT_START = 2'd3
  } cmdAct_e;

  // status bit positions
  localparam int STS_ERR  = 1;
  localparam int STS_ABT  = 2;
  localparam int STS_DONE = 3;
  localparam int STS_IRQ  = 4;
  localparam int STICKY_W = STS_DONE - STS_ERR + 1;

  typedef struct packed {
    logic                ldCmd;
    logic                ldStartCnt;
    logic                ldStartAddr;
    logic                ldStartDesc;
    logic                snapshot;
    logic [STICKY_W-1:0] stsClr;
  } regStrobes_t;
endpackage

// File: rtl/dmachan_ctrl.sv
module dmachan_ctrl
  import dmachan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [REG_IDX_W-1:0] addr,
  input  logic [STS_DONE:0]    wrLow,
  input  logic                 clearOnRead,
  output regStrobes_t          strobes,
  output logic                 startPulse,
  output logic                 stopPulse,
  output logic                 abortPulse
);
  logic    cmdWrite;
  logic    statWrite;
  logic    statRead;
  cmdAct_e act;

  assign cmdWrite  = wrEn && (addr == IDX_CMD);
  assign statWrite = wrEn && (addr == IDX_STAT);
  assign statRead  = rdEn && (addr == IDX_STAT);
  assign act       = cmdAct_e'(wrLow[1:0]);

  always_comb begin
    strobes             = '0;
    strobes.ldCmd       = cmdWrite;
    strobes.ldStartCnt  = wrEn && (addr == IDX_SCNT);
    strobes.ldStartAddr = wrEn && (addr == IDX_SADDR);
    strobes.ldStartDesc = wrEn && (addr == IDX_SDESC);
    strobes.snapshot    = cmdWrite && (act == ACT_START);
    if (strobes.snapshot)
      strobes.stsClr = '1;
    else if (statWrite && !clearOnRead)
      strobes.stsClr = wrLow[STS_DONE:STS_ERR];
    else if (statRead && clearOnRead)
      strobes.stsClr = '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      startPulse <= cmdWrite && (act == ACT_START);
      stopPulse  <= cmdWrite && (act == ACT_IDLE);
      abortPulse <= cmdWrite && (act == ACT_ABORT);
    end
  end
endmodule

// File: rtl/dmachan_datapath.sv
module dmachan_datapath
  import dmachan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobes_t          strobes,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [STICKY_W-1:0]  evtSet,
  input  logic                 scsiIrq,
  input  logic [REG_IDX_W-1:0] addr,
  output logic [DATA_W-1:0]    rdData
);
  localparam logic [DATA_W-1:0] WADDR_RST = '1;
  localparam logic [DATA_W-1:0] WDESC_RST = ~(DATA_W'(2));

  logic [DATA_W-1:0]   cmdReg, sCnt, sAddr, sDesc, wCnt, wAddr, wDesc;
  logic [STICKY_W-1:0] sticky;
  logic [DATA_W-1:0]   statView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      sCnt   <= '0;
      sAddr  <= '0;
      sDesc  <= '0;
      wCnt   <= '0;
      wAddr  <= WADDR_RST;
      wDesc  <= WDESC_RST;
      sticky <= '0;
    end else begin
      if (strobes.ldCmd)       cmdReg <= wrData;
      if (strobes.ldStartCnt)  sCnt   <= wrData;
      if (strobes.ldStartAddr) sAddr  <= wrData;
      if (strobes.ldStartDesc) sDesc  <= wrData;
      if (strobes.snapshot) begin
        wCnt  <= sCnt;
        wAddr <= sAddr;
        wDesc <= sDesc;
      end
      sticky <= (sticky & ~strobes.stsClr) | evtSet;
    end
  end

  always_comb begin
    statView                   = '0;
    statView[STS_DONE:STS_ERR] = sticky;
    statView[STS_IRQ]          = scsiIrq;
  end

  always_comb begin
    unique case (regIdx_e'(addr))
      IDX_CMD:   rdData = cmdReg;
      IDX_SCNT:  rdData = sCnt;
      IDX_SADDR: rdData = sAddr;
      IDX_WCNT:  rdData = wCnt;
      IDX_WADDR: rdData = wAddr;
      IDX_STAT:  rdData = statView;
      IDX_SDESC: rdData = sDesc;
      IDX_WDESC: rdData = wDesc;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmachan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [REG_IDX_W-1:0] addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 clearOnRead,
  input  logic                 scsiIrq,
  input  logic [STICKY_W-1:0]  evtSet,
  output logic                 startPulse,
  output logic                 stopPulse,
  output logic                 abortPulse
);
  regStrobes_t strobes;

  dmachan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrLow(wrData[STS_DONE:0]), .clearOnRead(clearOnRead), .strobes(strobes),
    .startPulse(startPulse), .stopPulse(stopPulse), .abortPulse(abortPulse)
  );

  dmachan_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .evtSet(evtSet), .scsiIrq(scsiIrq), .addr(addr), .rdData(rdData)
  );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dmachan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [REG_IDX_W-1:0] addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic                 clearOnRead,
  input logic                 scsiIrq,
  input logic [STICKY_W-1:0]  evtSet,
  input logic                 startPulse,
  input logic                 stopPulse,
  input logic                 abortPulse
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && startPulse) |-> $past(wrEn && addr == 3'd0 && wrData[1:0] == 2'd3));

  // R5
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && stopPulse) |-> $past(wrEn && addr == 3'd0 && wrData[1:0] == 2'd0));

  // R5
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && abortPulse) |-> $past(wrEn && addr == 3'd0 && wrData[1:0] == 2'd2));

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startPulse, stopPulse, abortPulse}));

  // R10
  irq_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd5) |-> (rdData[4] == scsiIrq));

  // R9
  cor_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(rdEn && !wrEn && addr == 3'd5 && clearOnRead && evtSet == 3'b000)
     && addr == 3'd5) |-> (rdData[3:1] == 3'b000));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .clearOnRead(clearOnRead),
  .scsiIrq(scsiIrq), .evtSet(evtSet), .startPulse(startPulse),
  .stopPulse(stopPulse), .abortPulse(abortPulse)
);

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        clearOnRead = 1'b0, scsiIrq = 1'b0;
  logic [2:0]  evtSet = '0;
  logic        startPulse, stopPulse, abortPulse;

  int checks = 0, failures = 0;
  bit finished = 0;

  // register model
  logic [31:0] mCmd, mSc, mSa, mSd, mWc, mWa, mWd;
  logic [2:0]  mSt;

  always #4 clk = ~clk;

  dma_chan_regs dut (.*);

  task automatic chk(input bit ok, input logic [31:0] act, input logic [31:0] exp,
                     input string req);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] idx);
    case (idx)
      3'd0: return mCmd;
      3'd1: return mSc;
      3'd2: return mSa;
      3'd3: return mWc;
      3'd4: return mWa;
      3'd5: return {27'd0, scsiIrq, mSt, 1'b0};
      3'd6: return mSd;
      default: return mWd;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1, 3'd2, 3'd6: return "R1";
      3'd3, 3'd4, 3'd7:       return "R2";
      default:                return "R10";
    endcase
  endfunction

  // one bus cycle: optional write or read plus engine events
  task automatic op(input bit w, input bit r, input logic [2:0] idx,
                    input logic [31:0] d, input logic [2:0] ev, input string req);
    logic [2:0] st;
    logic [2:0] expP;
    @(negedge clk);
    wrEn = w; rdEn = r; addr = idx; wrData = d; evtSet = ev;
    #1;
    if (r) chk(rdData === expRead(idx), rdData, expRead(idx), req);
    st = mSt; expP = 3'b000;
    if (w) begin
      case (idx)
        3'd0: begin
          mCmd = d;
          case (d[1:0])
            2'd0: expP = 3'b010;
            2'd2: expP = 3'b001;
            2'd3: begin expP = 3'b100; mWc = mSc; mWa = mSa; mWd = mSd; st = 3'b000; end
            default: ;
          endcase
        end
        3'd1: mSc = d;
        3'd2: mSa = d;
        3'd6: mSd = d;
        3'd5: if (!clearOnRead) st = st & ~d[3:1];
        default: ;
      endcase
    end
    if (r && idx == 3'd5 && clearOnRead) st = 3'b000;
    mSt = st | ev;
    @(negedge clk);
    wrEn = 0; rdEn = 0; evtSet = '0;
    // R6: pulse appears in the cycle after the write, one at a time
    chk({startPulse, stopPulse, abortPulse} === expP,
        {29'd0, startPulse, stopPulse, abortPulse}, {29'd0, expP}, "R6");
  endtask

  task automatic rd(input logic [2:0] idx, input string req);
    op(0, 1, idx, 32'h0, 3'b000, req);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mCmd = 0; mSc = 0; mSa = 0; mSd = 0; mWc = 0;
    mWa = 32'hFFFF_FFFF; mWd = 32'hFFFF_FFFD; mSt = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3: reset values of every slot
    for (int i = 0; i < 8; i++) rd(3'(i), "R3");

    // R1: writable slots, with flush command (R5: no pulse)
    op(1, 0, 3'd1, 32'h0000_1200, 3'b000, "R1");
    op(1, 0, 3'd2, 32'hABCD_0040, 3'b000, "R1");
    op(1, 0, 3'd6, 32'h1357_9BDF, 3'b000, "R1");
    op(1, 0, 3'd0, 32'h0000_00F5, 3'b000, "R5");
    rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd2, "R1"); rd(3'd6, "R1");
    rd(3'd3, "R5"); rd(3'd4, "R5");

    // R2: working slots ignore writes
    op(1, 0, 3'd3, 32'h1111_1111, 3'b000, "R2");
    op(1, 0, 3'd4, 32'h2222_2222, 3'b000, "R2");
    op(1, 0, 3'd7, 32'h3333_3333, 3'b000, "R2");
    rd(3'd3, "R2"); rd(3'd4, "R2"); rd(3'd7, "R2");

    // R7 events, R8 write-one-to-clear
    op(0, 0, 3'd0, 32'h0, 3'b111, "R7");
    rd(3'd5, "R7");
    op(1, 0, 3'd5, 32'h0000_0004, 3'b000, "R8");
    rd(3'd5, "R8");
    // R7: set wins over simultaneous clear
    op(1, 0, 3'd5, 32'h0000_000E, 3'b100, "R7");
    rd(3'd5, "R7");

    // R9 clear-on-read; writes ignored
    clearOnRead = 1'b1;
    op(0, 0, 3'd0, 32'h0, 3'b011, "R9");
    op(1, 0, 3'd5, 32'h0000_000E, 3'b000, "R9");
    rd(3'd5, "R9");
    rd(3'd5, "R9");
    clearOnRead = 1'b0;

    // R10 live interrupt merge
    scsiIrq = 1'b1; rd(3'd5, "R10");
    scsiIrq = 1'b0; rd(3'd5, "R10");

    // R4 start snapshot, R5 idle and abort
    op(0, 0, 3'd0, 32'h0, 3'b101, "R4");
    op(1, 0, 3'd0, 32'h0000_0083, 3'b000, "R4");
    rd(3'd3, "R4"); rd(3'd4, "R4"); rd(3'd7, "R4"); rd(3'd5, "R4");
    op(1, 0, 3'd0, 32'h0000_0002, 3'b000, "R5");
    op(1, 0, 3'd0, 32'h0000_0040, 3'b000, "R5");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0]  idx;
      logic [31:0] d;
      logic [2:0]  ev;
      int          kind;
      idx  = 3'($urandom_range(0, 7));
      d    = $urandom;
      ev   = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      kind = $urandom_range(0, 9);
      if ($urandom_range(0, 15) == 0) clearOnRead = ~clearOnRead;
      if ($urandom_range(0, 7) == 0)  scsiIrq = ~scsiIrq;
      if (kind < 4)      op(1, 0, idx, d, ev, tagFor(idx));
      else if (kind < 9) op(0, 1, idx, 32'h0, ev, tagFor(idx));
      else               op(0, 0, 3'd0, 32'h0, ev, "R7");
    end
    for (int i = 0; i < 8; i++) rd(3'(i), tagFor(3'(i)));

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule